// File: doc/BRIEF.md
# Synchronized wakeup MAC controller

This controller sequences the medium access of a sensor node in a network where every node wakes at the same instants. It runs on the slow always-on timer clock, one clock cycle per timer tick. A phase counter counts ticks modulo a programmable period and keeps running in every state. When the counter reads zero, a node that is asleep wakes. It then listens for a programmable number of ticks. If the channel was busy it waits for a request-to-send from a peer and receives. If the channel was quiet and data is pending, it sends its own request-to-send and waits a bounded time for clear-to-send before it transmits. If neither holds, it goes straight back to sleep.

The current state drives every power enable and clock gate of the node directly: the radio blocks, the MAC logic, the memory controller clock, the general-purpose processor, the fast clock, and the read and write enables of the data RAM. A time-synchronisation layer corrects the node's notion of time with a single-cycle adjust write, which replaces the counter value in one step.

All inputs are plain control pins. No data streams through the block, so it has no valid/ready interface. The adjust write is a one-cycle strobe that is always taken.

Top module: `swmac_ctrl`

## Requirements
- R1: While `rst_n` is low the state code is 0 (sleep), `time_now` is 0, `blk_en` is all zero and both RAM enables are low.
- R2: Without an adjust write, `time_now` rises by one per tick and wraps from `period_ticks`-1 to 0.
- R3: A node in sleep (code 0) enters carrier sense (code 1) on the tick after `time_now` reads 0. A node in any other state ignores that instant and stays where it is.
- R4: Carrier sense lasts exactly `sense_ticks` ticks. If no carrier was seen and no data is pending, the state is sleep on the next tick.
- R5: With data pending and no carrier seen, carrier sense is followed by the request-to-send state (code 2) for one tick, and then by the clear-to-send wait (code 3).
- R6: In the clear-to-send wait, a `cts_det` pulse moves the node to data transmit (code 4). Without one, the node returns to sleep after `cts_wait_ticks` ticks, and `data_pending` is left for the next period.
- R7: Data transmit holds until `tx_done`, then returns to sleep.
- R8: A carrier seen on any tick of carrier sense wins over pending data. The node goes to the request wait (code 5), which moves to receive (code 6) on `rts_det`, or returns to sleep after `cts_wait_ticks` ticks.
- R9: Receive holds until `rx_done` and then moves to upper-layer processing (code 7). That state holds until `proc_done`, then returns to sleep.
- R10: An adjust write loads `adj_value` into the counter on the next tick and overrides both the increment and the wrap. Wakeup follows the loaded value.
- R11: `blk_en` bits are: 0 power amplifier, 1 synthesizer, 2 gain stage, 3 converter, 4 image filter, 5 demodulator, 6 MAC logic, 7 memory controller clock, 8 processor, 9 fast clock.
  - Sleep: all bits off and no RAM access.
  - Transmit-class states (codes 2, 4): bits 0, 1, 6, 7, 9 on, RAM read.
  - Receive-class states (codes 1, 3, 5, 6): bits 1 to 7 and 9 on, RAM write.
  - Processing (code 7): bits 6 to 9 on, RAM read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on timer clock, one cycle per tick |
| rst_n | input | 1 | Active-low synchronous reset |
| period_ticks | input | TW | Wakeup period in ticks |
| sense_ticks | input | TW | Carrier-sense window in ticks |
| cts_wait_ticks | input | TW | Handshake wait limit in ticks |
| adj_wr | input | 1 | One-tick time-adjust strobe |
| adj_value | input | TW | Corrected phase to load |
| data_pending | input | 1 | Upper layer has data to send |
| carrier_det | input | 1 | Channel energy detected |
| rts_det | input | 1 | Request-to-send received strobe |
| cts_det | input | 1 | Clear-to-send received strobe |
| tx_done | input | 1 | Data transmission finished |
| rx_done | input | 1 | Data reception finished |
| proc_done | input | 1 | Upper-layer processing finished |
| time_now | output | TW | Current phase within the period |
| wake | output | 1 | High while the phase reads zero |
| state_code | output | 3 | Current state code |
| blk_en | output | 10 | Per-block power and clock enables |
| ram_rd_en | output | 1 | Data RAM read enable |
| ram_wr_en | output | 1 | Data RAM write enable |

## Verification
The assertions take for granted that the configuration inputs stay constant outside reset. They also assume `period_ticks` is at least 2, that `sense_ticks` and `cts_wait_ticks` are at least 1, and that any adjusted phase is below the period. Under those conditions the counter never leaves its range, and each strobe is seen as a single-tick pulse. The stimulus programs the three durations once, before reset is released, and never changes them. It loads only adjust values smaller than the period, and it raises each detect or done strobe for exactly one tick in the state that consumes it.

// File: rtl/swmac_pkg.sv
package swmac_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_SENSE = 3'd1,
    ST_RTS   = 3'd2,
    ST_CTSW  = 3'd3,
    ST_TXD   = 3'd4,
    ST_RTSW  = 3'd5,
    ST_RXD   = 3'd6,
    ST_PROC  = 3'd7
  } swmac_state_e;

  typedef enum logic [1:0] {
    PC_OFF  = 2'd0,
    PC_TX   = 2'd1,
    PC_RX   = 2'd2,
    PC_PROC = 2'd3
  } swmac_pclass_e;

  localparam int EN_PA     = 0;
  localparam int EN_PLL    = 1;
  localparam int EN_VGA    = 2;
  localparam int EN_ADC    = 3;
  localparam int EN_IRF    = 4;
  localparam int EN_BB     = 5;
  localparam int EN_MAC    = 6;
  localparam int EN_MEMCLK = 7;
  localparam int EN_CPU    = 8;
  localparam int EN_FCLK   = 9;
  localparam int NBLK      = 10;
endpackage

// File: rtl/swmac_timebase.sv
module swmac_timebase #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period_ticks,
  input  logic          adj_wr,
  input  logic [TW-1:0] adj_value,
  output logic [TW-1:0] count_o,
  output logic          wake_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] count_q;
  logic [TW-1:0] count_d;
  logic          at_end;

  assign at_end = (count_q == period_ticks - ONE);

  // The adjust load wins over the increment, so the phase changes in one step.
  always_comb begin
    if (adj_wr)      count_d = adj_value;
    else if (at_end) count_d = '0;
    else             count_d = count_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // Wakeup compare uses only the registered phase.
  assign count_o = count_q;
  assign wake_o  = (count_q == '0);

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q < period_ticks);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_wr && !at_end) |=> (count_q == $past(count_q) + ONE));

  assert_count_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_wr && at_end) |=> (count_q == '0));

  assert_adjust_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adj_wr |=> (count_q == $past(adj_value)));
endmodule

// File: rtl/swmac_seq.sv
module swmac_seq
  import swmac_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake_i,
  input  logic [TW-1:0] sense_ticks,
  input  logic [TW-1:0] cts_wait_ticks,
  input  logic          data_pending,
  input  logic          carrier_det,
  input  logic          rts_det,
  input  logic          cts_det,
  input  logic          tx_done,
  input  logic          rx_done,
  input  logic          proc_done,
  output swmac_state_e  state_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  swmac_state_e  st_q, st_d;
  logic [TW-1:0] win_q;
  logic          busy_q;
  logic          sense_end, wait_end, busy_now;

  assign sense_end = (win_q == sense_ticks - ONE);
  assign wait_end  = (win_q == cts_wait_ticks - ONE);
  assign busy_now  = busy_q | carrier_det;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_SLEEP: if (wake_i) st_d = ST_SENSE;
      ST_SENSE: begin
        if (sense_end) begin
          if (busy_now)          st_d = ST_RTSW;
          else if (data_pending) st_d = ST_RTS;
          else                   st_d = ST_SLEEP;
        end
      end
      ST_RTS:  st_d = ST_CTSW;
      ST_CTSW: begin
        if (cts_det)       st_d = ST_TXD;
        else if (wait_end) st_d = ST_SLEEP;
      end
      ST_TXD:  if (tx_done) st_d = ST_SLEEP;
      ST_RTSW: begin
        if (rts_det)       st_d = ST_RXD;
        else if (wait_end) st_d = ST_SLEEP;
      end
      ST_RXD:  if (rx_done)   st_d = ST_PROC;
      ST_PROC: if (proc_done) st_d = ST_SLEEP;
      default: st_d = ST_SLEEP;
    endcase
  end

  // Window counter and busy flag restart on every state change.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_SLEEP;
      win_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) begin
        win_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        win_q  <= win_q + ONE;
        busy_q <= busy_now;
      end
    end
  end

  assign state_o = st_q;

  assert_sleep_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && !wake_i) |=> (st_q == ST_SLEEP));

  assert_sense_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SENSE && win_q < sense_ticks - ONE) |=> (st_q == ST_SENSE));

  assert_rts_one_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RTS) |=> (st_q == ST_CTSW));

  assert_cts_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CTSW) |-> (win_q < cts_wait_ticks));

  assert_tx_after_cts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TXD && $past(st_q) != ST_TXD) |-> $past(cts_det));
endmodule

// File: rtl/swmac_power.sv
module swmac_power
  import swmac_pkg::*;
(
  input  swmac_state_e    state_i,
  output logic [NBLK-1:0] en_o,
  output logic            ram_rd_o,
  output logic            ram_wr_o
);
  swmac_pclass_e pc;

  always_comb begin
    case (state_i)
      ST_SLEEP:                  pc = PC_OFF;
      ST_RTS, ST_TXD:            pc = PC_TX;
      ST_PROC:                   pc = PC_PROC;
      default:                   pc = PC_RX;
    endcase
  end

  always_comb begin
    en_o     = '0;
    ram_rd_o = 1'b0;
    ram_wr_o = 1'b0;
    if (pc != PC_OFF) begin
      en_o[EN_MAC]    = 1'b1;
      en_o[EN_MEMCLK] = 1'b1;
      en_o[EN_FCLK]   = 1'b1;
    end
    case (pc)
      PC_TX: begin
        en_o[EN_PA]  = 1'b1;
        en_o[EN_PLL] = 1'b1;
        ram_rd_o     = 1'b1;
      end
      PC_RX: begin
        en_o[EN_PLL] = 1'b1;
        en_o[EN_VGA] = 1'b1;
        en_o[EN_ADC] = 1'b1;
        en_o[EN_IRF] = 1'b1;
        en_o[EN_BB]  = 1'b1;
        ram_wr_o     = 1'b1;
      end
      PC_PROC: begin
        en_o[EN_CPU] = 1'b1;
        ram_rd_o     = 1'b1;
        ram_wr_o     = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/swmac_ctrl.sv
module swmac_ctrl
  import swmac_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period_ticks,
  input  logic [TW-1:0] sense_ticks,
  input  logic [TW-1:0] cts_wait_ticks,
  input  logic          adj_wr,
  input  logic [TW-1:0] adj_value,
  input  logic          data_pending,
  input  logic          carrier_det,
  input  logic          rts_det,
  input  logic          cts_det,
  input  logic          tx_done,
  input  logic          rx_done,
  input  logic          proc_done,
  output logic [TW-1:0] time_now,
  output logic          wake,
  output logic [2:0]    state_code,
  output logic [9:0]    blk_en,
  output logic          ram_rd_en,
  output logic          ram_wr_en
);
  swmac_state_e st;
  logic         wk;

  swmac_timebase #(.TW(TW)) u_tb (
    .clk(clk), .rst_n(rst_n), .period_ticks(period_ticks),
    .adj_wr(adj_wr), .adj_value(adj_value),
    .count_o(time_now), .wake_o(wk)
  );

  swmac_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wake_i(wk),
    .sense_ticks(sense_ticks), .cts_wait_ticks(cts_wait_ticks),
    .data_pending(data_pending), .carrier_det(carrier_det),
    .rts_det(rts_det), .cts_det(cts_det),
    .tx_done(tx_done), .rx_done(rx_done), .proc_done(proc_done),
    .state_o(st)
  );

  swmac_power u_pwr (
    .state_i(st), .en_o(blk_en), .ram_rd_o(ram_rd_en), .ram_wr_o(ram_wr_en)
  );

  assign wake       = wk;
  assign state_code = st;

  assert_sleep_dark_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0) |-> (blk_en == '0 && !ram_rd_en && !ram_wr_en));

  assert_pa_needs_synth_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blk_en[EN_PA] |-> blk_en[EN_PLL]);

  assert_tx_rx_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_en[EN_PA] && blk_en[EN_VGA]));

  assert_cpu_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blk_en[EN_CPU] |-> (state_code == 3'd7 && !blk_en[EN_PLL]));
endmodule

// File: tb/swmac_ctrl_tb.sv
module swmac_ctrl_tb;
  localparam int TW = 16;
  localparam int PER = 40;
  localparam int TON = 4;
  localparam int TL  = 5;
  localparam logic [9:0] P_OFF  = 10'h000;
  localparam logic [9:0] P_TX   = 10'h2C3;
  localparam logic [9:0] P_RX   = 10'h2FE;
  localparam logic [9:0] P_PROC = 10'h3C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] period_ticks = TW'(PER);
  logic [TW-1:0] sense_ticks = TW'(TON);
  logic [TW-1:0] cts_wait_ticks = TW'(TL);
  logic adj_wr = 0;
  logic [TW-1:0] adj_value = '0;
  logic data_pending = 0, carrier_det = 0, rts_det = 0, cts_det = 0;
  logic tx_done = 0, rx_done = 0, proc_done = 0;
  logic [TW-1:0] time_now;
  logic wake;
  logic [2:0] state_code;
  logic [9:0] blk_en;
  logic ram_rd_en, ram_wr_en;

  int nvec = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  swmac_ctrl #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .period_ticks(period_ticks),
    .sense_ticks(sense_ticks), .cts_wait_ticks(cts_wait_ticks),
    .adj_wr(adj_wr), .adj_value(adj_value), .data_pending(data_pending),
    .carrier_det(carrier_det), .rts_det(rts_det), .cts_det(cts_det),
    .tx_done(tx_done), .rx_done(rx_done), .proc_done(proc_done),
    .time_now(time_now), .wake(wake), .state_code(state_code),
    .blk_en(blk_en), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic wait_zero;
    while (time_now != '0) tick();
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  task automatic enter_sense(input string req);
    wait_zero();
    tick();
    chk(req, "state after wake", 32'(state_code), 32'd1);
    chk(req, "phase after wake", 32'(time_now), 32'd1);
  endtask

  task automatic t_reset;
    repeat (3) tick();
    chk("R1", "state", 32'(state_code), 32'd0);
    chk("R1", "time", 32'(time_now), 32'd0);
    chk("R1", "enables", 32'(blk_en), 32'(P_OFF));
    chk("R1", "ram", 32'({ram_rd_en, ram_wr_en}), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_sense;
    enter_sense("R3");
    chk("R11", "sense enables", 32'(blk_en), 32'(P_RX));
    chk("R11", "sense ram write", 32'({ram_rd_en, ram_wr_en}), 32'b01);
    repeat (TON - 1) tick();
    chk("R4", "still sensing at last tick", 32'(state_code), 32'd1);
    tick();
    chk("R4", "back to sleep", 32'(state_code), 32'd0);
    chk("R11", "sleep enables", 32'(blk_en), 32'(P_OFF));
  endtask

  task automatic t_time_step;
    logic [TW-1:0] t0;
    t0 = time_now;
    tick();
    chk("R2", "increment", 32'(time_now), 32'(t0 + 1));
    while (time_now != TW'(PER - 1)) tick();
    tick();
    chk("R2", "wrap", 32'(time_now), 32'd0);
    tick();
    chk("R3", "wake from wrap", 32'(state_code), 32'd1);
    repeat (TON) tick();
    chk("R4", "idle return", 32'(state_code), 32'd0);
  endtask

  task automatic t_send_ok;
    data_pending = 1'b1;
    enter_sense("R3");
    repeat (TON) tick();
    chk("R5", "rts state", 32'(state_code), 32'd2);
    chk("R11", "rts enables", 32'(blk_en), 32'(P_TX));
    tick();
    chk("R5", "cts wait", 32'(state_code), 32'd3);
    cts_det = 1'b1;
    tick();
    cts_det = 1'b0;
    chk("R6", "transmit on cts", 32'(state_code), 32'd4);
    chk("R11", "tx ram read", 32'({ram_rd_en, ram_wr_en}), 32'b10);
    repeat (3) tick();
    chk("R7", "holds until done", 32'(state_code), 32'd4);
    tx_done = 1'b1;
    tick();
    tx_done = 1'b0;
    data_pending = 1'b0;
    chk("R7", "sleep after tx", 32'(state_code), 32'd0);
  endtask

  task automatic t_cts_timeout;
    data_pending = 1'b1;
    enter_sense("R3");
    repeat (TON + 1) tick();
    chk("R5", "cts wait", 32'(state_code), 32'd3);
    repeat (TL - 1) tick();
    chk("R6", "still waiting", 32'(state_code), 32'd3);
    tick();
    chk("R6", "timeout to sleep", 32'(state_code), 32'd0);
    enter_sense("R6");
    repeat (TON) tick();
    chk("R6", "pending retried next period", 32'(state_code), 32'd2);
    repeat (TL + 1) tick();
    data_pending = 1'b0;
    chk("R6", "second timeout", 32'(state_code), 32'd0);
  endtask

  task automatic t_receive;
    enter_sense("R3");
    carrier_det = 1'b1;
    tick();
    carrier_det = 1'b0;
    repeat (TON - 2) tick();
    chk("R8", "sense not cut short", 32'(state_code), 32'd1);
    tick();
    chk("R8", "request wait", 32'(state_code), 32'd5);
    rts_det = 1'b1;
    tick();
    rts_det = 1'b0;
    chk("R8", "receive on rts", 32'(state_code), 32'd6);
    chk("R11", "rx enables", 32'(blk_en), 32'(P_RX));
    rx_done = 1'b1;
    tick();
    rx_done = 1'b0;
    chk("R9", "processing", 32'(state_code), 32'd7);
    chk("R11", "proc enables", 32'(blk_en), 32'(P_PROC));
    chk("R11", "proc ram", 32'({ram_rd_en, ram_wr_en}), 32'b11);
    wait_zero();
    tick();
    chk("R3", "wake ignored while busy", 32'(state_code), 32'd7);
    proc_done = 1'b1;
    tick();
    proc_done = 1'b0;
    chk("R9", "sleep after proc", 32'(state_code), 32'd0);
  endtask

  task automatic t_rts_timeout_priority;
    data_pending = 1'b1;
    enter_sense("R3");
    repeat (TON - 1) tick();
    carrier_det = 1'b1;
    tick();
    carrier_det = 1'b0;
    chk("R8", "carrier beats pending", 32'(state_code), 32'd5);
    repeat (TL - 1) tick();
    chk("R8", "request wait held", 32'(state_code), 32'd5);
    tick();
    data_pending = 1'b0;
    chk("R8", "request timeout", 32'(state_code), 32'd0);
  endtask

  task automatic t_adjust;
    adj_value = TW'(20);
    adj_wr = 1'b1;
    tick();
    adj_wr = 1'b0;
    chk("R10", "load", 32'(time_now), 32'd20);
    tick();
    chk("R10", "count on from load", 32'(time_now), 32'd21);
    while (time_now != TW'(PER - 1)) tick();
    adj_value = TW'(10);
    adj_wr = 1'b1;
    tick();
    adj_wr = 1'b0;
    chk("R10", "load overrides wrap", 32'(time_now), 32'd10);
    chk("R10", "no wake on override", 32'(state_code), 32'd0);
    tick();
    chk("R10", "still asleep", 32'(state_code), 32'd0);
    adj_value = '0;
    adj_wr = 1'b1;
    tick();
    adj_wr = 1'b0;
    chk("R10", "load zero", 32'(time_now), 32'd0);
    tick();
    chk("R10", "wake follows load", 32'(state_code), 32'd1);
    repeat (TON) tick();
    chk("R4", "idle after adjusted wake", 32'(state_code), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #2;
    t_reset();
    t_idle_sense();
    t_time_step();
    t_send_ok();
    t_cts_timeout();
    t_receive();
    t_rts_timeout_priority();
    t_adjust();
    finish_run();
  end
endmodule